// File: doc/BRIEF.md
# Disk Transfer Engine With Block Buffer

This block sits between a host processor, a disk-side byte stream and system memory. The host sets up a transfer with ordinary register stores: a sector number, a direction, a byte length and a memory address. It then writes a start register. From that point the engine works without the processor.

When moving data from disk to memory, the engine first collects one whole 512-byte block and the 16-bit checksum that follows it into an internal buffer. The checksum is the count of set bits in the block. Only after the block is complete does the engine copy the buffer to memory as 32-bit words through a bus master port. Because of this, stalls on the memory side can never cost a disk byte.

When moving data from memory to disk, the engine first fills the buffer by reading memory. It then streams the block out, followed by a checksum it computes itself. Status and checksum errors can be read back from a status register.

Top module: `disk_dma_ctrl`

## Requirements
- R1: Register offsets: sector at 0x00 (32 bits), control at 0x04 (bit 0 is the direction, 1 meaning disk to memory), length at 0x08 (low 16 bits kept), memory address at 0x0C (32 bits), start at 0x10, status at 0x14. Each setup register reads back what was written. The start register and unused bits read as zero. After reset every register, status included, reads zero.
- R2: A store to 0x10 while idle starts a transfer. In the next cycle the status register shows bit 0 (busy) set, and bit 1 (done) and bit 2 (checksum error) cleared.
- R3: While busy, stores to the setup registers and to the start register have no effect.
- R4: For the disk-to-memory direction, the engine raises a command strobe for exactly one cycle, carrying the sector and a read flag of 1. It then accepts 512 block bytes followed by two checksum bytes, low byte first.
- R5: After a disk-to-memory transfer, status bit 2 is set exactly when the received checksum differs from the number of 1 bits in the 512 received bytes.
- R6: Memory words are written as follows. Word i holds block bytes 4i to 4i+3, with byte 4i in bits 7:0. It is written at the programmed address plus 4i. The word count is length/4, or 128 when the length is 512 or more. A request that is not accepted keeps its address and data unchanged.
- R7: Busy clears and done sets in the cycle after the final handshake, not before. The final handshake is the last memory word accepted, or the last checksum byte sent, or the checksum received when there are no words to copy.
- R8: For the memory-to-disk direction, the engine reads the word count from memory and raises the command strobe with a read flag of 0. It then streams 512 bytes, where bytes at or beyond 4 times the word count are zero. It follows them with the ones-count checksum of those bytes, low byte first. Output data holds while the output is not ready.
- R9: No memory request is issued while the engine is accepting disk input bytes.
- R10: A length of 0 still moves the whole disk block but makes no memory request, and the transfer ends with done set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register store strobe |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 32 | Register store data |
| reg_rdata | output | 32 | Register load data for reg_addr |
| dsk_cmd_valid | output | 1 | One-cycle disk command strobe |
| dsk_cmd_sector | output | 32 | Sector for the command |
| dsk_cmd_read | output | 1 | 1 = disk to memory, 0 = memory to disk |
| dsk_in_valid | input | 1 | Disk input byte valid |
| dsk_in_data | input | 8 | Disk input byte |
| dsk_in_ready | output | 1 | Engine accepts a disk input byte |
| dsk_out_valid | output | 1 | Disk output byte valid |
| dsk_out_data | output | 8 | Disk output byte |
| dsk_out_ready | input | 1 | Disk side accepts the output byte |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_write | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | 32 | Memory byte address |
| mem_req_wdata | output | 32 | Memory write data |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_rd_valid | input | 1 | Memory read data valid |
| mem_rd_data | input | 32 | Memory read data |

## Verification
The hardest situation to reach from the ports is a register store that arrives while a transfer is in flight. Without stalls, the transfer would end before the host side could touch it. The stalled vectors throttle the memory ready, the disk valid and the disk output ready. This keeps a transfer alive for hundreds of cycles. During that window the bench stores new sector, length and start values, then reads them back after completion and counts command strobes. The same throttling makes memory requests wait, which exposes any request that changes while it is waiting. Corrupted checksums and lengths of 0, 40, 64 and above 512 push the word count and the error bit to their edges.

// File: rtl/disk_dma_pkg.sv
package disk_dma_pkg;
    // register byte offsets seen by the host
    localparam logic [4:0] RA_SECTOR = 5'h00;
    localparam logic [4:0] RA_CTRL   = 5'h04;
    localparam logic [4:0] RA_LEN    = 5'h08;
    localparam logic [4:0] RA_ADDR   = 5'h0C;
    localparam logic [4:0] RA_GO     = 5'h10;
    localparam logic [4:0] RA_STAT   = 5'h14;

    // status bit positions
    localparam int SB_BUSY = 0;
    localparam int SB_DONE = 1;
    localparam int SB_ERR  = 2;

    // checksum travels as two bytes
    localparam int CK_W = 16;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RD_CMD,
        ST_RD_DATA,
        ST_RD_CK_LO,
        ST_RD_CK_HI,
        ST_MEM_WR,
        ST_MEM_RQ,
        ST_MEM_WT,
        ST_WR_CMD,
        ST_WR_DATA,
        ST_WR_CK_LO,
        ST_WR_CK_HI
    } xfer_e;
endpackage

// File: rtl/disk_dma_regs.sv
module disk_dma_regs
    import disk_dma_pkg::*;
#(
    parameter int SECT_W = 32,
    parameter int LEN_W  = 16,
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [4:0]        addr,
    input  logic [31:0]       wdata,
    input  logic              busy,
    input  logic              done,
    input  logic              err,
    output logic [31:0]       rdata,
    output logic [SECT_W-1:0] sector,
    output logic              dir_rd,
    output logic [LEN_W-1:0]  len,
    output logic [ADDR_W-1:0] base,
    output logic              go
);
    typedef struct packed {
        logic [SECT_W-1:0] sector;
        logic              dir;
        logic [LEN_W-1:0]  len;
        logic [ADDR_W-1:0] base;
    } setup_t;

    setup_t r_d, r_q;
    logic   open_wr;

    assign open_wr = we && !busy;

    always_comb begin
        r_d = r_q;
        if (open_wr) begin
            case (addr)
                RA_SECTOR: r_d.sector = wdata[SECT_W-1:0];
                RA_CTRL:   r_d.dir    = wdata[0];
                RA_LEN:    r_d.len    = wdata[LEN_W-1:0];
                RA_ADDR:   r_d.base   = wdata[ADDR_W-1:0];
                default:   ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        rdata = '0;
        case (addr)
            RA_SECTOR: rdata[SECT_W-1:0] = r_q.sector;
            RA_CTRL:   rdata[0]          = r_q.dir;
            RA_LEN:    rdata[LEN_W-1:0]  = r_q.len;
            RA_ADDR:   rdata[ADDR_W-1:0] = r_q.base;
            RA_STAT: begin
                rdata[SB_BUSY] = busy;
                rdata[SB_DONE] = done;
                rdata[SB_ERR]  = err;
            end
            default:   ;
        endcase
    end

    assign go     = open_wr && (addr == RA_GO);
    assign sector = r_q.sector;
    assign dir_rd = r_q.dir;
    assign len    = r_q.len;
    assign base   = r_q.base;
endmodule

// File: rtl/disk_dma_buf.sv
module disk_dma_buf #(
    parameter int BLK_BYTES = 512
) (
    input  logic                         clk,
    input  logic                         bwe,
    input  logic [$clog2(BLK_BYTES)-1:0] baddr,
    input  logic [7:0]                   bdata,
    input  logic                         wwe,
    input  logic [$clog2(BLK_BYTES)-3:0] waddr,
    input  logic [31:0]                  wdata,
    output logic [7:0]                   rbyte,
    output logic [31:0]                  rword
);
    localparam int BA_W = $clog2(BLK_BYTES);
    localparam int WA_W = BA_W - 2;

    logic [7:0] mem_q [BLK_BYTES];

    always_ff @(posedge clk) begin
        if (bwe) begin
            mem_q[baddr] <= bdata;
        end else if (wwe) begin
            for (int l = 0; l < 4; l++) begin
                mem_q[{waddr, 2'(l)}] <= wdata[8*l +: 8];
            end
        end
    end

    assign rbyte = mem_q[baddr];

    for (genvar g = 0; g < 4; g++) begin : g_lane
        assign rword[8*g +: 8] = mem_q[{waddr, 2'(g)}];
    end
endmodule

// File: rtl/disk_dma_csum.sv
module disk_dma_csum #(
    parameter int SUM_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             add,
    input  logic [7:0]       din,
    output logic [SUM_W-1:0] sum
);
    logic [SUM_W-1:0] sum_d, sum_q;

    always_comb begin
        sum_d = sum_q;
        if (clr)      sum_d = '0;
        else if (add) sum_d = sum_q + SUM_W'($countones(din));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sum_q <= '0;
        else        sum_q <= sum_d;
    end

    assign sum = sum_q;
endmodule

// File: rtl/disk_dma_ctrl.sv
module disk_dma_ctrl
    import disk_dma_pkg::*;
#(
    parameter int BLK_BYTES = 512,
    parameter int SECT_W    = 32,
    parameter int LEN_W     = 16,
    parameter int ADDR_W    = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [4:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              dsk_cmd_valid,
    output logic [SECT_W-1:0] dsk_cmd_sector,
    output logic              dsk_cmd_read,
    input  logic              dsk_in_valid,
    input  logic [7:0]        dsk_in_data,
    output logic              dsk_in_ready,
    output logic              dsk_out_valid,
    output logic [7:0]        dsk_out_data,
    input  logic              dsk_out_ready,
    output logic              mem_req_valid,
    output logic              mem_req_write,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic [31:0]       mem_req_wdata,
    input  logic              mem_req_ready,
    input  logic              mem_rd_valid,
    input  logic [31:0]       mem_rd_data
);
    localparam int BA_W  = $clog2(BLK_BYTES);
    localparam int WORDS = BLK_BYTES / 4;
    localparam int WA_W  = BA_W - 2;
    localparam int CNT_W = WA_W + 1;

    typedef struct packed {
        xfer_e           st;
        logic [BA_W-1:0] bidx;
        logic [WA_W-1:0] widx;
        logic [7:0]      ck_lo;
        logic            done;
        logic            err;
    } ctl_t;

    ctl_t c_d, c_q;

    logic              busy, go, dir_rd;
    logic [SECT_W-1:0] sector;
    logic [LEN_W-1:0]  len;
    logic [ADDR_W-1:0] base;
    logic [CNT_W-1:0]  nwords;
    logic              buf_bwe, buf_wwe;
    logic [31:0]       buf_wdata, buf_rword;
    logic [7:0]        buf_rbyte;
    logic              sum_clr, sum_add;
    logic [7:0]        sum_din;
    logic [CK_W-1:0]   sum;
    logic              fill_step;
    logic              last_byte, last_word, last_fill, fill_live;
    logic              stat_done, stat_err;

    assign busy      = (c_q.st != ST_IDLE);
    assign stat_done = c_q.done;
    assign stat_err  = c_q.err;

    disk_dma_regs #(
        .SECT_W(SECT_W),
        .LEN_W (LEN_W),
        .ADDR_W(ADDR_W)
    ) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (reg_we),
        .addr  (reg_addr),
        .wdata (reg_wdata),
        .busy  (busy),
        .done  (stat_done),
        .err   (stat_err),
        .rdata (reg_rdata),
        .sector(sector),
        .dir_rd(dir_rd),
        .len   (len),
        .base  (base),
        .go    (go)
    );

    disk_dma_buf #(
        .BLK_BYTES(BLK_BYTES)
    ) u_buf (
        .clk  (clk),
        .bwe  (buf_bwe),
        .baddr(c_q.bidx),
        .bdata(dsk_in_data),
        .wwe  (buf_wwe),
        .waddr(c_q.widx),
        .wdata(buf_wdata),
        .rbyte(buf_rbyte),
        .rword(buf_rword)
    );

    disk_dma_csum #(
        .SUM_W(CK_W)
    ) u_csum (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (sum_clr),
        .add  (sum_add),
        .din  (sum_din),
        .sum  (sum)
    );

    // words to move between buffer and memory
    always_comb begin
        if (len >= LEN_W'(BLK_BYTES)) nwords = CNT_W'(WORDS);
        else                          nwords = CNT_W'(len[BA_W-1:2]);
    end

    assign last_byte = (c_q.bidx == BA_W'(BLK_BYTES - 1));
    assign last_word = ({1'b0, c_q.widx} == (nwords - CNT_W'(1)));
    assign last_fill = (c_q.widx == WA_W'(WORDS - 1));
    assign fill_live = ({1'b0, c_q.widx} < nwords);
    assign sum_din   = (c_q.st == ST_WR_DATA) ? buf_rbyte : dsk_in_data;

    assign dsk_cmd_sector = sector;
    assign dsk_cmd_read   = dir_rd;
    assign mem_req_addr   = base + ADDR_W'({c_q.widx, 2'b00});
    assign mem_req_wdata  = buf_rword;

    always_comb begin
        c_d           = c_q;
        buf_bwe       = 1'b0;
        buf_wwe       = 1'b0;
        buf_wdata     = '0;
        sum_clr       = 1'b0;
        sum_add       = 1'b0;
        fill_step     = 1'b0;
        dsk_cmd_valid = 1'b0;
        dsk_in_ready  = 1'b0;
        dsk_out_valid = 1'b0;
        dsk_out_data  = buf_rbyte;
        mem_req_valid = 1'b0;
        mem_req_write = 1'b0;

        unique case (c_q.st)
            ST_IDLE: begin
                if (go) begin
                    c_d.done = 1'b0;
                    c_d.err  = 1'b0;
                    c_d.bidx = '0;
                    c_d.widx = '0;
                    sum_clr  = 1'b1;
                    c_d.st   = dir_rd ? ST_RD_CMD : ST_MEM_RQ;
                end
            end
            ST_RD_CMD: begin
                dsk_cmd_valid = 1'b1;
                c_d.st        = ST_RD_DATA;
            end
            ST_RD_DATA: begin
                dsk_in_ready = 1'b1;
                if (dsk_in_valid) begin
                    buf_bwe  = 1'b1;
                    sum_add  = 1'b1;
                    c_d.bidx = c_q.bidx + BA_W'(1);
                    if (last_byte) c_d.st = ST_RD_CK_LO;
                end
            end
            ST_RD_CK_LO: begin
                dsk_in_ready = 1'b1;
                if (dsk_in_valid) begin
                    c_d.ck_lo = dsk_in_data;
                    c_d.st    = ST_RD_CK_HI;
                end
            end
            ST_RD_CK_HI: begin
                dsk_in_ready = 1'b1;
                if (dsk_in_valid) begin
                    c_d.err  = ({dsk_in_data, c_q.ck_lo} != sum);
                    c_d.widx = '0;
                    if (nwords == '0) begin
                        c_d.st   = ST_IDLE;
                        c_d.done = 1'b1;
                    end else begin
                        c_d.st = ST_MEM_WR;
                    end
                end
            end
            ST_MEM_WR: begin
                mem_req_valid = 1'b1;
                mem_req_write = 1'b1;
                if (mem_req_ready) begin
                    if (last_word) begin
                        c_d.st   = ST_IDLE;
                        c_d.done = 1'b1;
                    end else begin
                        c_d.widx = c_q.widx + WA_W'(1);
                    end
                end
            end
            ST_MEM_RQ: begin
                if (fill_live) begin
                    mem_req_valid = 1'b1;
                    if (mem_req_ready) c_d.st = ST_MEM_WT;
                end else begin
                    buf_wwe   = 1'b1;
                    fill_step = 1'b1;
                end
            end
            ST_MEM_WT: begin
                if (mem_rd_valid) begin
                    buf_wwe   = 1'b1;
                    buf_wdata = mem_rd_data;
                    fill_step = 1'b1;
                    c_d.st    = ST_MEM_RQ;
                end
            end
            ST_WR_CMD: begin
                dsk_cmd_valid = 1'b1;
                c_d.st        = ST_WR_DATA;
            end
            ST_WR_DATA: begin
                dsk_out_valid = 1'b1;
                if (dsk_out_ready) begin
                    sum_add  = 1'b1;
                    c_d.bidx = c_q.bidx + BA_W'(1);
                    if (last_byte) c_d.st = ST_WR_CK_LO;
                end
            end
            ST_WR_CK_LO: begin
                dsk_out_valid = 1'b1;
                dsk_out_data  = sum[7:0];
                if (dsk_out_ready) c_d.st = ST_WR_CK_HI;
            end
            ST_WR_CK_HI: begin
                dsk_out_valid = 1'b1;
                dsk_out_data  = sum[15:8];
                if (dsk_out_ready) begin
                    c_d.st   = ST_IDLE;
                    c_d.done = 1'b1;
                end
            end
            default: c_d.st = ST_IDLE;
        endcase

        // advance the buffer fill, one word per step
        if (fill_step) begin
            if (last_fill) begin
                c_d.st   = ST_WR_CMD;
                c_d.bidx = '0;
            end else begin
                c_d.widx = c_q.widx + WA_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '{st: ST_IDLE, default: '0};
        else        c_q <= c_d;
    end
endmodule

// File: rtl/disk_dma_chk.sv
module disk_dma_chk
    import disk_dma_pkg::*;
#(
    parameter int SECT_W = 32,
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              done,
    input logic              reg_we,
    input logic [4:0]        reg_addr,
    input logic [SECT_W-1:0] sector,
    input logic              dsk_cmd_valid,
    input logic              dsk_cmd_read,
    input logic              dsk_in_ready,
    input logic              dsk_out_valid,
    input logic              dsk_out_ready,
    input logic [7:0]        dsk_out_data,
    input logic              mem_req_valid,
    input logic              mem_req_ready,
    input logic              mem_req_write,
    input logic [ADDR_W-1:0] mem_req_addr,
    input logic [31:0]       mem_req_wdata
);
    p_go_starts_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && reg_we && reg_addr == RA_GO) |=> busy);

    p_sector_locked_r3: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(sector));

    p_cmd_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        dsk_cmd_valid |=> !dsk_cmd_valid);

    p_req_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=>
            (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_wdata)
             && $stable(mem_req_write)));

    p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> !busy);

    p_req_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> busy);

    p_out_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (dsk_out_valid && !dsk_out_ready) |=> (dsk_out_valid && $stable(dsk_out_data)));

    p_read_dir_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_write) |-> !dsk_cmd_read);

    p_no_mem_in_fill_r9: assert property (@(posedge clk) disable iff (!rst_n)
        dsk_in_ready |-> !mem_req_valid);
endmodule

bind disk_dma_ctrl disk_dma_chk #(
    .SECT_W(SECT_W),
    .ADDR_W(ADDR_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .busy         (busy),
    .done         (stat_done),
    .reg_we       (reg_we),
    .reg_addr     (reg_addr),
    .sector       (sector),
    .dsk_cmd_valid(dsk_cmd_valid),
    .dsk_cmd_read (dsk_cmd_read),
    .dsk_in_ready (dsk_in_ready),
    .dsk_out_valid(dsk_out_valid),
    .dsk_out_ready(dsk_out_ready),
    .dsk_out_data (dsk_out_data),
    .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write),
    .mem_req_addr (mem_req_addr),
    .mem_req_wdata(mem_req_wdata)
);

// File: tb/disk_dma_ctrl_tb_top.sv
module disk_dma_ctrl_tb_top;
    import disk_dma_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int BLK        = 512;
    localparam int NW         = BLK / 4;
    localparam int MEMW       = 2048;
    localparam int NVEC       = 7;

    typedef struct packed {
        logic        dir;
        logic        stall;
        logic        corrupt;
        logic [15:0] sector;
        logic [15:0] len;
        logic [15:0] base;
        logic [7:0]  seed;
    } vec_t;

    localparam vec_t VECS [NVEC] = '{
        '{1'b1, 1'b0, 1'b0, 16'd5,   16'd512, 16'h0000, 8'd3},
        '{1'b1, 1'b1, 1'b1, 16'h77,  16'd64,  16'h0400, 8'd9},
        '{1'b0, 1'b0, 1'b0, 16'd12,  16'd512, 16'h0800, 8'd5},
        '{1'b0, 1'b1, 1'b0, 16'd200, 16'd40,  16'h0C00, 8'd17},
        '{1'b1, 1'b1, 1'b0, 16'd3,   16'd700, 16'h1000, 8'd101},
        '{1'b1, 1'b0, 1'b0, 16'd9,   16'd0,   16'h1400, 8'd1},
        '{1'b0, 1'b0, 1'b0, 16'd44,  16'd0,   16'h1800, 8'd7}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        dsk_cmd_valid, dsk_cmd_read;
    logic [31:0] dsk_cmd_sector;
    logic        dsk_in_valid = 1'b0;
    logic [7:0]  dsk_in_data = '0;
    logic        dsk_in_ready;
    logic        dsk_out_valid;
    logic [7:0]  dsk_out_data;
    logic        dsk_out_ready = 1'b0;
    logic        mem_req_valid, mem_req_write;
    logic [31:0] mem_req_addr, mem_req_wdata;
    logic        mem_req_ready = 1'b0;
    logic        mem_rd_valid = 1'b0;
    logic [31:0] mem_rd_data = '0;

    disk_dma_ctrl dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .reg_we        (reg_we),
        .reg_addr      (reg_addr),
        .reg_wdata     (reg_wdata),
        .reg_rdata     (reg_rdata),
        .dsk_cmd_valid (dsk_cmd_valid),
        .dsk_cmd_sector(dsk_cmd_sector),
        .dsk_cmd_read  (dsk_cmd_read),
        .dsk_in_valid  (dsk_in_valid),
        .dsk_in_data   (dsk_in_data),
        .dsk_in_ready  (dsk_in_ready),
        .dsk_out_valid (dsk_out_valid),
        .dsk_out_data  (dsk_out_data),
        .dsk_out_ready (dsk_out_ready),
        .mem_req_valid (mem_req_valid),
        .mem_req_write (mem_req_write),
        .mem_req_addr  (mem_req_addr),
        .mem_req_wdata (mem_req_wdata),
        .mem_req_ready (mem_req_ready),
        .mem_rd_valid  (mem_rd_valid),
        .mem_rd_data   (mem_rd_data)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input logic [7:0] seed, input int i);
        return 8'(i * seed + (i >> 3)) ^ seed;
    endfunction

    function automatic int words_for(input logic [15:0] len);
        return (len >= 16'(BLK)) ? NW : int'(len) / 4;
    endfunction

    // bench-side models, updated away from the active edge
    logic [31:0] tbmem [MEMW];
    logic [7:0]  src   [BLK + 2];
    logic [7:0]  sink  [BLK + 2];
    int  cyc = 0;
    bit  stall = 0;
    bit  src_on = 0;
    bit  src_acc = 0;
    int  k = 0;
    int  n_memwr = 0, n_memrd = 0, n_out = 0, n_cmd = 0, n_overlap = 0;
    int  exp_w = 0, cur_base = 0;
    bit  cur_dir = 0;
    bit  end_arm = 0, end_pend = 0;
    int  rd_pend = 0, rd_idx = 0;
    logic [31:0] cmd_sector = '0;
    logic        cmd_read = 1'b0;

    always @(negedge clk) begin
        bit mrdy, ordy;
        int idx;
        cyc++;
        if (end_pend) begin
            end_pend = 0;
            chk(reg_rdata[2:0] == 3'b010 || reg_rdata[2:0] == 3'b110,
                "R7 done after final handshake", reg_rdata, 32'h2);
        end
        // memory read response
        mem_rd_valid = 1'b0;
        if (rd_pend > 0) begin
            rd_pend--;
            if (rd_pend == 0) begin
                mem_rd_valid = 1'b1;
                mem_rd_data  = tbmem[rd_idx];
            end
        end
        // memory request side
        mrdy = stall ? (cyc % 3 != 0) : 1'b1;
        mem_req_ready = mrdy;
        if (mem_req_valid && dsk_in_ready) n_overlap++;
        if (mem_req_valid && mrdy) begin
            idx = int'(mem_req_addr[12:2]);
            chk(mem_req_addr[1:0] == 2'b00 && idx >= cur_base && idx < cur_base + exp_w,
                "R6 address in range", mem_req_addr, 32'(cur_base * 4));
            if (mem_req_write) begin
                tbmem[idx] = mem_req_wdata;
                n_memwr++;
                if (end_arm && cur_dir && n_memwr == exp_w) begin
                    chk(reg_rdata[1:0] == 2'b01, "R7 busy through last word", reg_rdata, 32'h1);
                    end_pend = 1;
                end
            end else begin
                n_memrd++;
                rd_idx  = idx;
                rd_pend = 2;
            end
        end
        // disk source
        if (src_acc) k++;
        dsk_in_valid = src_on && (k < BLK + 2) && !(stall && (cyc % 4 == 1));
        dsk_in_data  = (k < BLK + 2) ? src[k] : 8'h00;
        src_acc      = dsk_in_valid && dsk_in_ready;
        // disk sink
        ordy = stall ? (cyc % 5 != 0) : 1'b1;
        dsk_out_ready = ordy;
        if (dsk_out_valid && ordy) begin
            if (n_out < BLK + 2) sink[n_out] = dsk_out_data;
            n_out++;
            if (end_arm && !cur_dir && n_out == BLK + 2) begin
                chk(reg_rdata[1:0] == 2'b01, "R7 busy through last checksum byte", reg_rdata, 32'h1);
                end_pend = 1;
            end
        end
        if (dsk_cmd_valid) begin
            n_cmd++;
            cmd_sector = dsk_cmd_sector;
            cmd_read   = dsk_cmd_read;
        end
    end

    task automatic reg_write(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we    = 1'b1;
        reg_addr  = a;
        reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_read(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic run_vec(input vec_t v);
        int          w;
        int          ones;
        logic [15:0] ck;
        logic [31:0] rv;
        logic [7:0]  eb;
        bit          finished;
        w        = words_for(v.len);
        cur_base = int'(v.base) / 4;
        exp_w    = w;
        cur_dir  = v.dir;
        ones     = 0;
        if (v.dir) begin
            for (int j = 0; j < BLK; j++) begin
                src[j] = pat(v.seed, j);
                ones += $countones(src[j]);
            end
            ck = 16'(ones) + (v.corrupt ? 16'd1 : 16'd0);
            src[BLK]     = ck[7:0];
            src[BLK + 1] = ck[15:8];
            for (int i = 0; i <= NW; i++) tbmem[cur_base + i] = 32'hDEAD_BEEF;
        end else begin
            for (int i = 0; i < NW; i++)
                tbmem[cur_base + i] = {pat(v.seed, 4*i+3), pat(v.seed, 4*i+2),
                                       pat(v.seed, 4*i+1), pat(v.seed, 4*i)};
        end
        n_memwr = 0; n_memrd = 0; n_out = 0; n_cmd = 0; n_overlap = 0;
        k = 0; src_acc = 0; end_pend = 0;
        stall   = v.stall;
        end_arm = (w > 0) || !v.dir;
        src_on  = v.dir;

        reg_write(RA_SECTOR, 32'(v.sector));
        reg_write(RA_CTRL, {31'd0, v.dir});
        reg_write(RA_LEN, 32'(v.len));
        reg_write(RA_ADDR, 32'(v.base));
        reg_write(RA_GO, 32'h1);
        reg_addr = RA_STAT;
        #1;
        chk(reg_rdata[2:0] == 3'b001, "R2 busy after start", reg_rdata, 32'h1);

        if (v.stall) begin
            // R3: stores during a transfer must not land
            reg_write(RA_SECTOR, 32'hBEEF_0000);
            reg_write(RA_LEN, 32'h4);
            reg_write(RA_GO, 32'h1);
            reg_addr = RA_STAT;
        end

        finished = 0;
        for (int t = 0; t < 20000 && !finished; t++) begin
            @(negedge clk);
            #1;
            if (!reg_rdata[SB_BUSY]) finished = 1;
        end
        chk(finished, "R7 transfer completes", {31'd0, finished}, 32'h1);
        src_on  = 0;
        end_arm = 0;
        @(negedge clk);
        #1;
        chk(reg_rdata[SB_DONE] == 1'b1, "R7 done set", reg_rdata, 32'h2);
        chk(n_cmd == 1, "R3 R4 single command strobe", n_cmd, 1);
        chk(cmd_sector == 32'(v.sector) && cmd_read == v.dir,
            "R4 command sector and direction", cmd_sector, 32'(v.sector));
        chk(n_overlap == 0, "R9 no memory request during disk input", n_overlap, 0);

        if (v.dir) begin
            chk(reg_rdata[SB_ERR] == v.corrupt, "R5 checksum error bit",
                {31'd0, reg_rdata[SB_ERR]}, {31'd0, v.corrupt});
            chk(k == BLK + 2, "R4 block and checksum consumed", k, BLK + 2);
            chk(n_memwr == w, "R6 R10 memory word count", n_memwr, w);
            for (int i = 0; i < w; i++) begin
                rv = {src[4*i+3], src[4*i+2], src[4*i+1], src[4*i]};
                chk(tbmem[cur_base + i] == rv, "R6 memory word packing", tbmem[cur_base + i], rv);
            end
            chk(tbmem[cur_base + w] == 32'hDEAD_BEEF, "R6 no write past count",
                tbmem[cur_base + w], 32'hDEAD_BEEF);
        end else begin
            chk(reg_rdata[SB_ERR] == 1'b0, "R5 no error on disk write", reg_rdata, 32'h2);
            chk(n_memrd == w && n_memwr == 0, "R8 R10 memory reads", n_memrd, w);
            chk(n_out == BLK + 2, "R8 output byte count", n_out, BLK + 2);
            ones = 0;
            for (int j = 0; j < BLK; j++) begin
                eb = (j < 4 * w) ? pat(v.seed, j) : 8'h00;
                ones += $countones(eb);
                chk(sink[j] == eb, "R8 output block byte", 32'(sink[j]), 32'(eb));
            end
            ck = 16'(ones);
            chk({sink[BLK + 1], sink[BLK]} == ck, "R8 output checksum low first",
                {16'd0, sink[BLK + 1], sink[BLK]}, {16'd0, ck});
        end

        reg_read(RA_SECTOR, rv);
        chk(rv == 32'(v.sector), "R3 sector unchanged by busy store", rv, 32'(v.sector));
        reg_read(RA_LEN, rv);
        chk(rv == 32'(v.len), "R3 length unchanged by busy store", rv, 32'(v.len));
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] rv;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // reset state
        reg_read(RA_STAT, rv);
        chk(rv == 32'h0, "R1 status after reset", rv, 32'h0);
        reg_read(RA_SECTOR, rv);
        chk(rv == 32'h0, "R1 sector after reset", rv, 32'h0);
        reg_read(RA_ADDR, rv);
        chk(rv == 32'h0, "R1 address after reset", rv, 32'h0);

        // register readback
        reg_write(RA_SECTOR, 32'h1234_5678);
        reg_write(RA_CTRL, 32'hFFFF_FFFF);
        reg_write(RA_LEN, 32'hFFFF_1234);
        reg_write(RA_ADDR, 32'hABCD_EF00);
        reg_read(RA_SECTOR, rv);
        chk(rv == 32'h1234_5678, "R1 sector readback", rv, 32'h1234_5678);
        reg_read(RA_CTRL, rv);
        chk(rv == 32'h1, "R1 control keeps bit 0 only", rv, 32'h1);
        reg_read(RA_LEN, rv);
        chk(rv == 32'h1234, "R1 length keeps low 16 bits", rv, 32'h1234);
        reg_read(RA_ADDR, rv);
        chk(rv == 32'hABCD_EF00, "R1 address readback", rv, 32'hABCD_EF00);
        reg_read(RA_GO, rv);
        chk(rv == 32'h0, "R1 start register reads zero", rv, 32'h0);
        reg_read(RA_STAT, rv);
        chk(rv == 32'h0, "R2 no start without store to 0x10", rv, 32'h0);

        for (int vi = 0; vi < NVEC; vi++) run_vec(VECS[vi]);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule